// File: doc/BRIEF.md
# DRAM Row-Buffer Locality Monitor with Layout Sweep

This block sits beside a memory request stream after the logical-to-physical address mapper and never stalls or alters it. For each accepted request it looks up the open row of the addressed bank and places the access in one of four classes: a miss (the bank holds no open row), a hit (the open row is the row asked for), a conflict (the bank is the same one the previous access used but the row differs), or a bank switch (a different bank from the previous access whose open row differs). It keeps one saturating counter per class plus a total. The row-hit ratio is reported as the pair hit count over total count, so no divider is needed.

Counting happens inside a measurement window, opened and closed by two strobes. A small sweep engine reuses the same window to score a layout parameter (the mapper's cursor). It walks the candidates from zero upward, one candidate per replay of the address trace. It compares each candidate's hit ratio against the best one so far by cross-multiplying the counts, and keeps the winner. The sweep FSM has five states: IDLE (waiting for a start), OPEN (one cycle that presents the candidate and opens a fresh window), RUN (the trace is replayed until the end-of-trace strobe), SCORE (one cycle that compares and either advances the candidate or leaves) and FINISH (one cycle that pulses completion). The transitions are IDLE→OPEN on sweep_go, OPEN→RUN always, RUN→SCORE on trace_end, SCORE→OPEN while candidates remain, SCORE→FINISH after the last one, and FINISH→IDLE always.

Top module: `row_conflict_monitor`

## Requirements
- R1: After reset every counter reads zero, the window is closed, the sweep is idle with try_cursor, best_cursor, best_hits and best_acc at zero, and every bank is closed.
- R2: The bank index is the 3-bit req_bank: bit 2 selects the group and bits 1:0 the bank in that group, giving 8 independent banks. An access to a bank with no open row counts as a miss and leaves that row open.
- R3: An access whose row equals the addressed bank's open row counts as a hit, whatever bank the previous access used.
- R4: An access to the same bank as the previous access with a different row counts as a conflict, and the new row becomes open.
- R5: An access to a different bank from the previous access, where that bank is open on another row, counts as a bank switch and never as a conflict.
- R6: acc_cnt counts every access counted in any class. Every counter saturates at its all-ones value instead of wrapping.
- R7: A window start zeroes all counters, closes all banks and forgets the previous bank. A request in the start cycle is dropped, and start wins over a stop in the same cycle. A request in the stop cycle is still counted. Requests outside the window leave the counters unchanged.
- R8: On sweep_go in IDLE, cand_last is captured and candidates 0..cand_last are tried in ascending order. Each pass shows its candidate on try_cursor with pass_open high for one cycle, and a window that opens at the end of that cycle and closes after the trace_end cycle. The access in the trace_end cycle is counted.
- R9: A candidate replaces the best when hits_new × acc_best > hits_best × acc_new. The first candidate is always taken, and on equal ratios the lower cursor is kept. best_hits and best_acc give the winner's counts.
- R10: sweep_done is high for exactly one cycle after the last candidate is scored. best_cursor stays unchanged from then until the next sweep_go. While the sweep is busy, sweep_go, win_start and win_stop have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_bank | input | 3 | Bank index {group, bank-in-group} |
| req_row | input | 16 | Row address of the request |
| win_start | input | 1 | Open a fresh measurement window (manual) |
| win_stop | input | 1 | Close the measurement window (manual) |
| sweep_go | input | 1 | Start a candidate sweep |
| cand_last | input | 4 | Highest candidate value to try |
| trace_end | input | 1 | Last cycle of one trace replay |
| hit_cnt | output | 32 | Hits in the window |
| miss_cnt | output | 32 | Accesses to closed banks |
| conflict_cnt | output | 32 | Same-bank row conflicts |
| switch_cnt | output | 32 | Bank switches to a differently opened bank |
| acc_cnt | output | 32 | Total counted accesses |
| win_active | output | 1 | Window is open |
| try_cursor | output | 4 | Candidate under test |
| pass_open | output | 1 | First cycle of a pass, the replay may begin next cycle |
| sweep_busy | output | 1 | Sweep is running |
| sweep_done | output | 1 | One-cycle completion pulse |
| best_cursor | output | 4 | Winning candidate |
| best_hits | output | 32 | Hit count of the winner |
| best_acc | output | 32 | Total count of the winner |

## Verification
On every cycle the assertions check the following: a window start really leaves zeroed counters behind an open window, the total never falls between starts and never trails the hit count, an OPEN cycle leads straight into a running window, the completion pulse lasts one cycle, and the winner stays still while the engine is idle. The class boundaries can only be shown by the bench scenarios. These are a return to a bank after another bank was used, the same cycle carrying both a request and a start or a stop, saturation, and which cursor wins or ties. In those scenarios a behavioural model replays the request streams and predicts every output on every clock.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    typedef enum logic [1:0] {
        ACC_MISS,
        ACC_HIT,
        ACC_SWITCH,
        ACC_CONFLICT
    } acc_kind_t;

    typedef enum logic [2:0] {
        SW_IDLE,
        SW_OPEN,
        SW_RUN,
        SW_SCORE,
        SW_FINISH
    } sweep_state_t;

endpackage

// File: rtl/rcm_bank_table.sv
module rcm_bank_table
    import rcm_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              upd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    output acc_kind_t         kind
);
    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0]  open_vec;
    logic [NBANK-1:0]  match_vec;
    logic [BANK_W-1:0] prev_bank_q;
    logic              prev_vld_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic             open_q;
        logic [ROW_W-1:0] row_q;
        logic             sel;
        assign sel = (bank == BANK_W'(b));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else if (clear) begin
                open_q <= 1'b0;
            end else if (upd && sel) begin
                open_q <= 1'b1;
                row_q  <= row;
            end
        end
        assign open_vec[b]  = open_q;
        assign match_vec[b] = open_q && (row_q == row);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_bank_q <= '0;
            prev_vld_q  <= 1'b0;
        end else if (clear) begin
            prev_vld_q  <= 1'b0;
        end else if (upd) begin
            prev_bank_q <= bank;
            prev_vld_q  <= 1'b1;
        end
    end

    always_comb begin
        if (!open_vec[bank])
            kind = ACC_MISS;
        else if (match_vec[bank])
            kind = ACC_HIT;
        else if (prev_vld_q && prev_bank_q == bank)
            kind = ACC_CONFLICT;
        else
            kind = ACC_SWITCH;
    end

endmodule

// File: rtl/rcm_counters.sv
module rcm_counters
    import rcm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             count_en,
    input  acc_kind_t        kind,
    output logic [CNT_W-1:0] hit_o,
    output logic [CNT_W-1:0] miss_o,
    output logic [CNT_W-1:0] conf_o,
    output logic [CNT_W-1:0] switch_o,
    output logic [CNT_W-1:0] acc_o
);
    localparam int NCNT = 5;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [NCNT-1:0]  inc;
    logic [CNT_W-1:0] val [NCNT];

    always_comb begin
        inc[0] = count_en && (kind == ACC_HIT);
        inc[1] = count_en && (kind == ACC_MISS);
        inc[2] = count_en && (kind == ACC_CONFLICT);
        inc[3] = count_en && (kind == ACC_SWITCH);
        inc[4] = count_en;
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        logic [CNT_W-1:0] c_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                c_q <= '0;
            else if (clear)
                c_q <= '0;
            else if (inc[g] && c_q != CNT_MAX)
                c_q <= c_q + CNT_W'(1);
        end
        assign val[g] = c_q;
    end

    assign hit_o    = val[0];
    assign miss_o   = val[1];
    assign conf_o   = val[2];
    assign switch_o = val[3];
    assign acc_o    = val[4];

endmodule

// File: rtl/rcm_sweep_fsm.sv
module rcm_sweep_fsm
    import rcm_pkg::*;
#(
    parameter int CUR_W = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CUR_W-1:0] cand_last,
    input  logic             trace_end,
    input  logic [CNT_W-1:0] hits,
    input  logic [CNT_W-1:0] acc,
    output logic [CUR_W-1:0] cursor,
    output logic [CUR_W-1:0] best_cursor,
    output logic [CNT_W-1:0] best_hits,
    output logic [CNT_W-1:0] best_acc,
    output logic             pass_open,
    output logic             busy,
    output logic             done,
    output logic             win_start_o,
    output logic             win_stop_o
);
    localparam int PROD_W = 2 * CNT_W;

    sweep_state_t     state_q, state_d;
    logic [CUR_W-1:0] cursor_q, last_q, best_q;
    logic [CNT_W-1:0] bh_q, ba_q;
    logic             have_q;
    logic [PROD_W-1:0] new_side, old_side;
    logic             better;

    assign new_side = {{CNT_W{1'b0}}, hits} * {{CNT_W{1'b0}}, ba_q};
    assign old_side = {{CNT_W{1'b0}}, bh_q} * {{CNT_W{1'b0}}, acc};
    assign better   = !have_q || (new_side > old_side);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE:   if (go) state_d = SW_OPEN;
            SW_OPEN:   state_d = SW_RUN;
            SW_RUN:    if (trace_end) state_d = SW_SCORE;
            SW_SCORE:  state_d = (cursor_q == last_q) ? SW_FINISH : SW_OPEN;
            SW_FINISH: state_d = SW_IDLE;
            default:   state_d = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SW_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cursor_q <= '0;
            last_q   <= '0;
            best_q   <= '0;
            bh_q     <= '0;
            ba_q     <= '0;
            have_q   <= 1'b0;
        end else if (state_q == SW_IDLE && go) begin
            cursor_q <= '0;
            last_q   <= cand_last;
            best_q   <= '0;
            bh_q     <= '0;
            ba_q     <= '0;
            have_q   <= 1'b0;
        end else if (state_q == SW_SCORE) begin
            if (better) begin
                best_q <= cursor_q;
                bh_q   <= hits;
                ba_q   <= acc;
                have_q <= 1'b1;
            end
            if (cursor_q != last_q)
                cursor_q <= cursor_q + CUR_W'(1);
        end
    end

    always_comb begin
        pass_open   = 1'b0;
        busy        = 1'b1;
        done        = 1'b0;
        win_start_o = 1'b0;
        win_stop_o  = 1'b0;
        unique case (state_q)
            SW_IDLE:   busy = 1'b0;
            SW_OPEN: begin
                pass_open   = 1'b1;
                win_start_o = 1'b1;
            end
            SW_RUN:    win_stop_o = trace_end;
            SW_SCORE:  ;
            SW_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign cursor      = cursor_q;
    assign best_cursor = best_q;
    assign best_hits   = bh_q;
    assign best_acc    = ba_q;

endmodule

// File: rtl/row_conflict_monitor.sv
module row_conflict_monitor
    import rcm_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    parameter int CNT_W  = 32,
    parameter int CUR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              win_start,
    input  logic              win_stop,
    input  logic              sweep_go,
    input  logic [CUR_W-1:0]  cand_last,
    input  logic              trace_end,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  miss_cnt,
    output logic [CNT_W-1:0]  conflict_cnt,
    output logic [CNT_W-1:0]  switch_cnt,
    output logic [CNT_W-1:0]  acc_cnt,
    output logic              win_active,
    output logic [CUR_W-1:0]  try_cursor,
    output logic              pass_open,
    output logic              sweep_busy,
    output logic              sweep_done,
    output logic [CUR_W-1:0]  best_cursor,
    output logic [CNT_W-1:0]  best_hits,
    output logic [CNT_W-1:0]  best_acc
);
    acc_kind_t kind;
    logic      fsm_start, fsm_stop;
    logic      start_eff, stop_eff;
    logic      count_en;
    logic      active_q;

    assign start_eff = sweep_busy ? fsm_start : win_start;
    assign stop_eff  = sweep_busy ? fsm_stop  : win_stop;
    assign count_en  = active_q && req_valid && !start_eff;

    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else if (start_eff)
            active_q <= 1'b1;
        else if (stop_eff)
            active_q <= 1'b0;
    end
    assign win_active = active_q;

    rcm_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_eff),
        .upd   (req_valid),
        .bank  (req_bank),
        .row   (req_row),
        .kind  (kind)
    );

    rcm_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_eff),
        .count_en (count_en),
        .kind     (kind),
        .hit_o    (hit_cnt),
        .miss_o   (miss_cnt),
        .conf_o   (conflict_cnt),
        .switch_o (switch_cnt),
        .acc_o    (acc_cnt)
    );

    rcm_sweep_fsm #(.CUR_W(CUR_W), .CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (sweep_go),
        .cand_last   (cand_last),
        .trace_end   (trace_end),
        .hits        (hit_cnt),
        .acc         (acc_cnt),
        .cursor      (try_cursor),
        .best_cursor (best_cursor),
        .best_hits   (best_hits),
        .best_acc    (best_acc),
        .pass_open   (pass_open),
        .busy        (sweep_busy),
        .done        (sweep_done),
        .win_start_o (fsm_start),
        .win_stop_o  (fsm_stop)
    );

endmodule

// File: rtl/rcm_checker.sv
module rcm_checker #(
    parameter int CNT_W = 32,
    parameter int CUR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_eff,
    input logic             sweep_go,
    input logic             sweep_busy,
    input logic             sweep_done,
    input logic             pass_open,
    input logic             win_active,
    input logic [CNT_W-1:0] acc_cnt,
    input logic [CNT_W-1:0] hit_cnt,
    input logic [CUR_W-1:0] try_cursor,
    input logic [CUR_W-1:0] best_cursor
);
    // R7
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_eff |=> (acc_cnt == '0 && win_active));

    // R6
    acc_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_eff |=> acc_cnt >= $past(acc_cnt));

    // R6
    hit_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cnt <= acc_cnt);

    // R8
    open_then_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_open |=> (win_active && !pass_open));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> !sweep_done);

    // R10
    best_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sweep_busy && !sweep_go) |=> $stable(best_cursor));

    // R9
    best_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> best_cursor <= try_cursor);
endmodule

bind row_conflict_monitor rcm_checker #(.CNT_W(CNT_W), .CUR_W(CUR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_eff   (start_eff),
    .sweep_go    (sweep_go),
    .sweep_busy  (sweep_busy),
    .sweep_done  (sweep_done),
    .pass_open   (pass_open),
    .win_active  (win_active),
    .acc_cnt     (acc_cnt),
    .hit_cnt     (hit_cnt),
    .try_cursor  (try_cursor),
    .best_cursor (best_cursor)
);

// File: tb/row_conflict_monitor_bench.sv
module row_conflict_monitor_bench;
    localparam int CW   = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_bank = '0;
    logic [15:0] req_row = '0;
    logic win_start = 1'b0, win_stop = 1'b0, sweep_go = 1'b0, trace_end = 1'b0;
    logic [3:0] cand_last = '0;
    logic [CW-1:0] hit_cnt, miss_cnt, conflict_cnt, switch_cnt, acc_cnt, best_hits, best_acc;
    logic win_active, pass_open, sweep_busy, sweep_done;
    logic [3:0] try_cursor, best_cursor;

    always #2.5 clk = ~clk;

    row_conflict_monitor #(.CNT_W(CW)) u_row_conflict_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .win_start(win_start), .win_stop(win_stop),
        .sweep_go(sweep_go), .cand_last(cand_last), .trace_end(trace_end),
        .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .conflict_cnt(conflict_cnt),
        .switch_cnt(switch_cnt), .acc_cnt(acc_cnt), .win_active(win_active),
        .try_cursor(try_cursor), .pass_open(pass_open), .sweep_busy(sweep_busy),
        .sweep_done(sweep_done), .best_cursor(best_cursor), .best_hits(best_hits),
        .best_acc(best_acc)
    );

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    // behavioural reference
    bit m_open [8];
    int m_row [8];
    int m_prev = -1;
    int m_hit, m_miss, m_conf, m_sw, m_acc;
    bit m_act;
    int m_st;          // 0 idle 1 open 2 run 3 score 4 finish
    int m_cur, m_last, m_best, m_bh, m_ba;
    bit m_have;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic model_reset();
        foreach (m_open[i]) begin m_open[i] = 0; m_row[i] = 0; end
        m_prev = -1; m_hit = 0; m_miss = 0; m_conf = 0; m_sw = 0; m_acc = 0;
        m_act = 0; m_st = 0; m_cur = 0; m_last = 0; m_best = 0; m_bh = 0; m_ba = 0; m_have = 0;
    endtask

    function automatic int sat(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    task automatic model_step(input bit v, input int b, input int r, input bit ws,
                              input bit wp, input bit go, input int last, input bit te);
        bit busy, st_e, sp_e, cnt;
        busy = (m_st != 0);
        st_e = busy ? (m_st == 1) : ws;
        sp_e = busy ? (m_st == 2 && te) : wp;
        cnt  = m_act && v && !st_e;
        case (m_st)
            0: if (go) begin
                   m_st = 1; m_cur = 0; m_last = last; m_have = 0;
                   m_best = 0; m_bh = 0; m_ba = 0;
               end
            1: m_st = 2;
            2: if (te) m_st = 3;
            3: begin
                   if (!m_have || longint'(m_hit) * m_ba > longint'(m_bh) * m_acc) begin
                       m_best = m_cur; m_bh = m_hit; m_ba = m_acc; m_have = 1;
                   end
                   if (m_cur == m_last) m_st = 4; else begin m_cur++; m_st = 1; end
               end
            default: m_st = 0;
        endcase
        if (cnt) begin
            m_acc = sat(m_acc);
            if (!m_open[b]) m_miss = sat(m_miss);
            else if (m_row[b] == r) m_hit = sat(m_hit);
            else if (m_prev == b) m_conf = sat(m_conf);
            else m_sw = sat(m_sw);
        end
        if (st_e) begin
            foreach (m_open[i]) m_open[i] = 0;
            m_prev = -1;
            m_hit = 0; m_miss = 0; m_conf = 0; m_sw = 0; m_acc = 0;
        end else if (v) begin
            m_open[b] = 1; m_row[b] = r; m_prev = b;
        end
        if (st_e) m_act = 1; else if (sp_e) m_act = 0;
    endtask

    task automatic compare_all();
        check(hit_cnt == CW'(m_hit), "R3 hit_cnt", hit_cnt, m_hit);
        check(miss_cnt == CW'(m_miss), "R2 miss_cnt", miss_cnt, m_miss);
        check(conflict_cnt == CW'(m_conf), "R4 conflict_cnt", conflict_cnt, m_conf);
        check(switch_cnt == CW'(m_sw), "R5 switch_cnt", switch_cnt, m_sw);
        check(acc_cnt == CW'(m_acc), "R6 acc_cnt", acc_cnt, m_acc);
        check(win_active == m_act, "R7 win_active", win_active, m_act);
        check(try_cursor == 4'(m_cur), "R8 try_cursor", try_cursor, m_cur);
        check(pass_open == (m_st == 1), "R8 pass_open", pass_open, m_st == 1);
        check(sweep_busy == (m_st != 0), "R10 sweep_busy", sweep_busy, m_st != 0);
        check(sweep_done == (m_st == 4), "R10 sweep_done", sweep_done, m_st == 4);
        check(best_cursor == 4'(m_best), "R9 best_cursor", best_cursor, m_best);
        check(best_hits == CW'(m_bh), "R9 best_hits", best_hits, m_bh);
        check(best_acc == CW'(m_ba), "R9 best_acc", best_acc, m_ba);
    endtask

    // one clock: drive after a falling edge, predict, compare at the next falling edge
    task automatic cyc(input bit v, input int b, input int r, input bit ws = 0,
                       input bit wp = 0, input bit go = 0, input int last = 0, input bit te = 0);
        req_valid = v; req_bank = 3'(b); req_row = 16'(r);
        win_start = ws; win_stop = wp; sweep_go = go; cand_last = 4'(last); trace_end = te;
        model_step(v, b, r, ws, wp, go, last, te);
        @(negedge clk);
        cycles++;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0);
    endtask

    // replay source: trace depends on the candidate under test
    function automatic int tr_bank(input int mode, input int c, input int i);
        if (mode == 0) return (c == 2) ? 0 : (i % 8);
        if (mode == 1) return i % 3;
        return (i >> c) % 8;
    endfunction
    function automatic int tr_row(input int mode, input int c, input int i);
        if (mode == 0) return (c == 2) ? 0 : i;
        if (mode == 1) return i / 3;
        return i >> (c + 3);
    endfunction

    task automatic run_sweep(input int last, input int mode, input int len);
        cyc(0, 0, 0, 0, 0, 1, last);
        while (m_st != 0) begin
            if (m_st == 2) begin
                int c;
                c = m_cur;
                for (int i = 0; i < len; i++)
                    // R10: manual window strobes and a second go mid-pass are ignored
                    cyc(1, tr_bank(mode, c, i), tr_row(mode, c, i), i == 3, i == 4, i == 5, 0, i == len - 1);
            end else begin
                cyc(0, 0, 0);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(acc_cnt == 0 && hit_cnt == 0 && !win_active && !sweep_busy && best_cursor == 0,
              "R1 reset state", acc_cnt, 0);
        compare_all();
        rst_n = 1'b1;
        idle(2);

        // classes in a manual window
        cyc(0, 0, 0, 1);
        cyc(1, 0, 5);     // miss R2
        cyc(1, 0, 5);     // hit R3
        cyc(1, 0, 7);     // conflict R4
        cyc(1, 1, 1);     // miss
        cyc(1, 0, 9);     // switch R5
        cyc(1, 1, 1);     // hit after other bank R3
        cyc(1, 4, 1);     // miss, group bit selects another bank R2
        check(hit_cnt == 2 && miss_cnt == 3 && conflict_cnt == 1 && switch_cnt == 1,
              "R5 class split", {hit_cnt, miss_cnt, conflict_cnt, switch_cnt}, 32'h02030101);
        cyc(1, 4, 1, 0, 1); // counted on stop cycle R7
        cyc(1, 4, 1);       // outside window R7
        check(acc_cnt == 8 && !win_active, "R7 stop cycle counted, outside ignored", acc_cnt, 8);
        cyc(1, 2, 2, 1, 1); // start wins, request dropped R7
        check(acc_cnt == 0 && win_active, "R7 start wins and clears", acc_cnt, 0);
        cyc(1, 2, 2);
        check(miss_cnt == 1, "R7 start-cycle request dropped, bank closed", miss_cnt, 1);

        // saturation R6
        for (int i = 0; i < 300; i++) cyc(1, 2, 2);
        check(hit_cnt == CW'(CMAX) && acc_cnt == CW'(CMAX), "R6 saturation", acc_cnt, CMAX);
        cyc(0, 0, 0, 0, 1);
        idle(2);

        // sweeps
        run_sweep(3, 0, 16);
        check(best_cursor == 2, "R9 best candidate", best_cursor, 2);
        idle(3);
        check(best_cursor == 2, "R10 best held after done", best_cursor, 2);
        run_sweep(2, 1, 12);
        check(best_cursor == 0, "R9 tie keeps lower", best_cursor, 0);
        run_sweep(4, 2, 40);
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule